// File: doc/BRIEF.md
# Half-Band Interpolation Chain

This block raises the sample rate of a signed data stream by four ahead of a digital-to-analog converter. Two 2x half-band interpolating stages are cascaded. Every accepted input sample yields two samples from the first stage, and each of those yields two samples from the second stage. All stages share one fixed symmetric coefficient set whose centre tap is a power of two.

A mode bit for each stage selects low-pass or high-pass behaviour. Low-pass keeps the baseband image. High-pass keeps the mirrored image in the upper half of that stage's output band. It does this by inverting the sign of every second stage output, which is the centre-tap phase. No coefficients are reloaded. Results are rounded to nearest and clamped to 16 bits.

The caller presents one sample with a one-cycle strobe at most once every four clocks. Four output samples then appear on consecutive cycles, each marked by its own strobe.

Top module: `hbi_chain`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `outValid` is 0 and `outData` is 0. Reset clears both delay lines to zero, so the first outputs after reset are computed from an all-zero history.
- R2: When `inValid` is high in cycle n, `outValid` is high in cycles n+3, n+4, n+5 and n+6. It is low in every cycle that is not three to six cycles after an accepted strobe.
- R3: Strobes on `inValid` are at least four cycles apart. At exactly four cycles apart, the outputs form an unbroken stream of one sample per clock.
- R4: Each stage keeps its last 26 input samples, with d0 the newest. For every input sample it emits two samples, in this order. First comes the filtered sample, the sum over j = 0..12 of k_j·(d_j + d_(25−j)). The weights k_0..k_12 are +5, −20, +50, −108, +206, −361, +597, −947, +1467, −2267, +3633, −6617, +20746. Second comes the centre sample, equal to d12 times 32768. The first stage's samples feed the second stage in the order they are emitted.
- R5: A stage result is its accumulated sum plus 16384, shifted arithmetically right by 15 and clamped to the range −32768..32767. Inputs whose signs match the weights drive the output into the clamp.
- R6: With a stage's high-pass bit at 1, that stage negates its centre sample, and −32768 maps to +32767. Its filtered sample does not change.
- R7: Both mode bits are sampled in the cycle `inValid` is high. The sampled values apply to all four outputs of that input. Values the bits take between strobes have no effect on any output.
- R8: With both stages low-pass and a constant input, once both delay lines are full every output sample equals that constant.
- R9: `outData` keeps its last value in every cycle in which `outValid` is low.
- R10: The output timing of R2 is the same for all four mode combinations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input sample strobe |
| inData | input | 16 | Input sample, two's complement |
| hpSel1 | input | 1 | First stage high-pass select |
| hpSel2 | input | 1 | Second stage high-pass select |
| outValid | output | 1 | Output sample strobe |
| outData | output | 16 | Output sample, two's complement |

## Verification
The assertions assume that `inValid` never repeats within four cycles and that reset is held for at least two clocks. The strobe-to-output timing and the hold of `outData` are only defined under those conditions. Every stimulus task spaces its strobes four or more cycles apart, and the bench holds reset for five clocks. Mode bits are toggled only between strobes, which keeps the stimulus inside these assumptions while still exercising R7.

// File: rtl/hbi_pkg.sv
`timescale 1ns/1ps
package hbi_pkg;
  localparam int HB_DW    = 16;
  localparam int HB_ACCW  = 40;
  localparam int HB_FRAC  = 15;
  localparam int HB_NSIDE = 13;

  // signed side weights, outermost first; the centre weight is 2**HB_FRAC
  localparam int HB_COEF [HB_NSIDE] = '{
    5, -20, 50, -108, 206, -361, 597, -947, 1467, -2267, 3633, -6617, 20746
  };

  typedef struct packed {
    logic s1Shift;
    logic s2ShiftA;
    logic s2ShiftB;
    logic outA;
    logic outB;
    logic neg1;
    logic neg2;
  } hbiStrobe_t;
endpackage

// File: rtl/hbi_stage.sv
`timescale 1ns/1ps
module hbi_stage import hbi_pkg::*; #(
  parameter int DW    = HB_DW,
  parameter int ACCW  = HB_ACCW,
  parameter int FRAC  = HB_FRAC,
  parameter int NSIDE = HB_NSIDE
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shiftEn,
  input  logic signed [DW-1:0] shiftIn,
  input  logic                 negCenter,
  output logic signed [DW-1:0] sideOut,
  output logic signed [DW-1:0] centerOut
);
  localparam int HIST = 2 * NSIDE;
  localparam int CIDX = NSIDE - 1;
  localparam logic signed [ACCW-1:0] RND_BIAS = {{(ACCW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
  localparam logic signed [DW-1:0]   MIN_S    = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0]   MAX_S    = ~MIN_S;
  localparam logic signed [ACCW-1:0] SAT_HI   = ACCW'(MAX_S);
  localparam logic signed [ACCW-1:0] SAT_LO   = ACCW'(MIN_S);

  logic signed [DW-1:0]   dly [HIST];
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] pairExt;
  logic signed [ACCW-1:0] coefExt;
  logic signed [ACCW-1:0] scaled;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST; i++) dly[i] <= '0;
    end else if (shiftEn) begin
      dly[0] <= shiftIn;
      for (int i = 1; i < HIST; i++) dly[i] <= dly[i-1];
    end
  end

  // symmetric pairs share one multiply each
  always_comb begin
    acc     = '0;
    pairExt = '0;
    coefExt = '0;
    for (int j = 0; j < NSIDE; j++) begin
      pairExt = ACCW'(dly[j]) + ACCW'(dly[HIST-1-j]);
      coefExt = ACCW'(HB_COEF[j]);
      acc     = acc + pairExt * coefExt;
    end
    scaled = (acc + RND_BIAS) >>> FRAC;
    if (scaled > SAT_HI)      sideOut = MAX_S;
    else if (scaled < SAT_LO) sideOut = MIN_S;
    else                      sideOut = scaled[DW-1:0];
  end

  // centre tap is a pure power of two: the scaled result is the sample itself
  always_comb begin
    if (!negCenter)             centerOut = dly[CIDX];
    else if (dly[CIDX] == MIN_S) centerOut = MAX_S;
    else                        centerOut = -dly[CIDX];
  end
endmodule

// File: rtl/hbi_ctrl.sv
`timescale 1ns/1ps
module hbi_ctrl import hbi_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       hpSel1,
  input  logic       hpSel2,
  output hbiStrobe_t st
);
  localparam int PIPE = 5;

  logic [PIPE-1:0] pipe;
  logic            mode1Q;
  logic            mode2A;
  logic            mode2B;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe   <= '0;
      mode1Q <= 1'b0;
      mode2A <= 1'b0;
      mode2B <= 1'b0;
    end else begin
      pipe <= {pipe[PIPE-2:0], inValid};
      if (inValid) begin
        mode1Q <= hpSel1;
        mode2A <= hpSel2;
      end
      if (pipe[2]) mode2B <= mode2A;
    end
  end

  always_comb begin
    st.s1Shift  = inValid;
    st.s2ShiftA = pipe[0];
    st.s2ShiftB = pipe[2];
    st.outA     = pipe[1] | pipe[3];
    st.outB     = pipe[2] | pipe[4];
    st.neg1     = mode1Q;
    st.neg2     = pipe[2] ? mode2A : mode2B;
  end
endmodule

// File: rtl/hbi_datapath.sv
`timescale 1ns/1ps
module hbi_datapath import hbi_pkg::*; #(
  parameter int DW = HB_DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  hbiStrobe_t           st,
  input  logic signed [DW-1:0] inData,
  output logic                 outValid,
  output logic signed [DW-1:0] outData
);
  logic signed [DW-1:0] s1Side, s1Center, s2Side, s2Center, s2In;

  hbi_stage #(.DW(DW)) u_stage1 (
    .clk(clk), .rst(rst), .shiftEn(st.s1Shift), .shiftIn(inData),
    .negCenter(st.neg1), .sideOut(s1Side), .centerOut(s1Center)
  );

  assign s2In = st.s2ShiftA ? s1Side : s1Center;

  hbi_stage #(.DW(DW)) u_stage2 (
    .clk(clk), .rst(rst), .shiftEn(st.s2ShiftA | st.s2ShiftB), .shiftIn(s2In),
    .negCenter(st.neg2), .sideOut(s2Side), .centerOut(s2Center)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= st.outA | st.outB;
      if (st.outA)      outData <= s2Side;
      else if (st.outB) outData <= s2Center;
    end
  end
endmodule

// File: rtl/hbi_chain.sv
`timescale 1ns/1ps
module hbi_chain import hbi_pkg::*; (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [15:0] inData,
  input  logic        hpSel1,
  input  logic        hpSel2,
  output logic        outValid,
  output logic [15:0] outData
);
  hbiStrobe_t st;

  hbi_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .hpSel1(hpSel1), .hpSel2(hpSel2), .st(st)
  );

  hbi_datapath #(.DW(16)) u_dp (
    .clk(clk), .rst(rst), .st(st), .inData(inData),
    .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/hbi_chain_chk.sv
`timescale 1ns/1ps
module hbi_chain_chk (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        outValid,
  input logic [15:0] outData
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!outValid && outData == 16'd0)); // R1

  AST_FIRST_OUT: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##3 outValid); // R2

  AST_LAST_OUT: assert property (@(posedge clk) disable iff (rst)
    inValid |-> ##6 outValid); // R10

  AST_OUT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($past(inValid, 3) || $past(inValid, 4) ||
                  $past(inValid, 5) || $past(inValid, 6))); // R2

  AST_IN_SPACING: assert property (@(posedge clk) disable iff (rst)
    inValid |=> !inValid ##1 !inValid ##1 !inValid); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData)); // R9
endmodule

bind hbi_chain hbi_chain_chk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .outValid(outValid), .outData(outData)
);

// File: tb/test_hbi_chain.sv
`timescale 1ns/1ps
module test_hbi_chain;
  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [15:0] inData;
  logic        hpSel1, hpSel2;
  logic        outValid;
  logic [15:0] outData;

  hbi_chain i_hbi_chain (
    .clk(clk), .rst(rst), .inValid(inValid), .inData(inData),
    .hpSel1(hpSel1), .hpSel2(hpSel2), .outValid(outValid), .outData(outData)
  );

  always #2 clk = ~clk;

  int    tests = 0;
  int    fails = 0;
  int    cyc   = 0;
  int    satHits = 0;
  bit    finished = 0;
  string curTag = "R1";
  int    expQ[$];
  int    timeQ[$];
  int    lastVals[4];
  int    h1[26];
  int    h2[26];
  int    wt[13] = '{5, -20, 50, -108, 206, -361, 597, -947, 1467, -2267, 3633, -6617, 20746};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int rsat(longint a);
    longint r;
    r = (a + 64'sd16384) >>> 15;
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  function automatic int sideOf(int h[26]);
    longint acc = 0;
    for (int j = 0; j < 13; j++) acc += longint'(wt[j]) * longint'(h[j] + h[25-j]);
    return rsat(acc);
  endfunction

  function automatic int centerOf(int h[26], bit hp);
    longint acc;
    acc = longint'(h[12]) * 32768;
    if (hp) acc = -acc;
    return rsat(acc);
  endfunction

  task automatic stage2Model(int x, bit hp2);
    for (int i = 25; i > 0; i--) h2[i] = h2[i-1];
    h2[0] = x;
    expQ.push_back(sideOf(h2));
    expQ.push_back(centerOf(h2, hp2));
  endtask

  task automatic chainModel(int x, bit hp1, bit hp2);
    int a, b;
    for (int i = 25; i > 0; i--) h1[i] = h1[i-1];
    h1[0] = x;
    a = sideOf(h1);
    b = centerOf(h1, hp1);
    stage2Model(a, hp2);
    stage2Model(b, hp2);
  endtask

  // one strobe, then gap-1 quiet cycles; wiggle flips the mode bits while quiet
  task automatic send(int x, bit m1, bit m2, int gap, bit wiggle);
    @(negedge clk);
    inValid = 1'b1;
    inData  = 16'(x);
    hpSel1  = m1;
    hpSel2  = m2;
    chainModel(x, m1, m2);
    for (int k = 3; k <= 6; k++) timeQ.push_back(cyc + k);
    @(negedge clk);
    inValid = 1'b0;
    if (wiggle) begin hpSel1 = ~m1; hpSel2 = ~m2; end
    repeat (gap - 2) @(negedge clk);
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  // output monitor: value against model and timing against strobe cycle
  always @(negedge clk) begin
    if (!rst && outValid) begin
      int act;
      act = int'($signed(outData));
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected output", act, 0);
      end else begin
        int e, t;
        e = expQ.pop_front();
        t = timeQ.pop_front();
        check(act == e, curTag, act, e);
        check(cyc == t, "R2 R10 timing", cyc, t);
      end
      if (act == 32767 || act == -32768) satHits++;
      for (int i = 0; i < 3; i++) lastVals[i] = lastVals[i+1];
      lastVals[3] = act;
    end
  end

  initial begin
    for (int i = 0; i < 26; i++) begin h1[i] = 0; h2[i] = 0; end
    for (int i = 0; i < 4; i++) lastVals[i] = 0;
    rst = 1'b1; inValid = 1'b0; inData = '0; hpSel1 = 1'b0; hpSel2 = 1'b0;
    repeat (5) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(outData == 16'd0, "R1 outData after reset", int'(outData), 0);

    // impulse through both low-pass stages
    curTag = "R4 impulse";
    send(32767, 0, 0, 4, 0);
    for (int i = 0; i < 30; i++) send(0, 0, 0, 4, 0);

    // signs matched to weights, oldest first
    curTag = "R5 saturation";
    satHits = 0;
    for (int i = 25; i >= 0; i--) begin
      bit pos;
      pos = (i >= 13) ? (i % 2 == 1) : (i % 2 == 0);
      send(pos ? 32767 : -32768, 0, 0, 4, 0);
    end
    for (int i = 0; i < 30; i++) send((i % 2) ? -32768 : 32767, 0, 0, 4, 0);
    repeat (8) @(negedge clk);
    check(satHits > 0, "R5 clamp reached", satHits, 1);

    curTag = "R6 stage1 high-pass";
    for (int i = 0; i < 40; i++) send(rnd16(), 1, 0, 4, 0);
    curTag = "R6 stage2 high-pass";
    for (int i = 0; i < 40; i++) send(rnd16(), 0, 1, 4, 0);
    curTag = "R6 most negative";
    for (int i = 0; i < 40; i++) send((i % 3 == 0) ? -32768 : rnd16(), 1, 1, 4, 0);

    curTag = "R7 mode sampling";
    for (int i = 0; i < 60; i++) send(rnd16(), 1'($urandom_range(1)), 1'($urandom_range(1)), 5 + (i % 3), 1);

    curTag = "R3 spacing";
    for (int i = 0; i < 60; i++) send(rnd16(), 1'($urandom_range(1)), 1'($urandom_range(1)), 4 + int'($urandom_range(3)), 0);

    curTag = "R8 DC";
    for (int i = 0; i < 45; i++) send(1000, 0, 0, 4, 0);
    repeat (8) @(negedge clk);
    for (int i = 0; i < 4; i++) check(lastVals[i] == 1000, "R8 settled DC", lastVals[i], 1000);

    // idle: output must hold
    check(outValid == 1'b0, "R9 idle strobe", int'(outValid), 0);
    check(int'($signed(outData)) == lastVals[3], "R9 held value", int'($signed(outData)), lastVals[3]);
    hpSel1 = 1'b1; hpSel2 = 1'b1;
    repeat (6) @(negedge clk);
    check(int'($signed(outData)) == lastVals[3], "R9 R7 held after idle mode change", int'($signed(outData)), lastVals[3]);
    check(expQ.size() == 0, "R2 all outputs delivered", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule